// File: doc/BRIEF.md
# SPI Master Shift Engine with Inter-Byte Clock Pause

This block is the serial core of an SPI master. It moves one transaction word of 8, 16, 24 or 32 bits: the byte that holds the top bits goes out first, and each byte goes out most significant bit first. While it sends, it samples the incoming line and packs the received bits into a word that is aligned to the top. The serial clock comes from the system clock through a half-period divider. The clock's resting level is chosen by a polarity input.

An optional byte-pause mode holds the serial clock at its resting level for a programmable time between successive bytes of the same word. The pause is counted in half serial-clock periods and lasts from half a period up to fifteen and a half periods. The same 4-bit pause value also serves the logic that spaces whole words. No pause follows the last byte of a word.

Software places the length code, polarity, pause enable, pause value and transmit word on the inputs, then pulses start. All of these are captured at the start. The block drives a single active-low select line for the whole word. It raises a one-cycle done pulse, and at that pulse the received word is valid.

Top module: `spi_gap_master`

## Requirements
- R1: `word_len` code 0, 1, 2, 3 selects 8, 16, 24, 32 bits. Exactly that many serial clock cycles (leading edges) occur per word.
- R2: `mosi` presents `tx_word[31]` first, then bits 30, 29 and so on downward. Bits of `tx_word` below the selected length never appear. `mosi` changes only on a trailing (active-to-idle) edge of `sclk`.
- R3: `miso` is sampled on each leading (idle-to-active) edge of `sclk`. The first sampled bit lands in `rx_word[31]`, and later bits fill downward. Bits of `rx_word` below the selected length read 0.
- R4: `sclk` rests at `cpol` whenever no word is in progress and throughout every pause. Each half period lasts `HALF_CYC` system clocks.
- R5: With `gap_en`=1, the pause between two successive bytes of a word adds (2·`gap_len`+1) idle half periods. The spacing between the last leading edge of one byte and the first leading edge of the next is therefore (2·`gap_len`+3) half periods, instead of the normal 2.
- R6: No pause follows the final byte of a word. With `gap_en`=0, every leading edge follows the previous one by exactly 2 half periods.
- R7: `done` is high for exactly one system clock, in the cycle after the final half period ends. `rx_word` is complete at that point and holds its value until the next accepted start.
- R8: A `start` pulse while a word is in progress is ignored. The current word's bits, length and result are unchanged, and no second word follows.
- R9: `ss_n` (and `busy` as its inverse) goes active on an accepted start. It stays active through the last bit and returns high in the same cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | Begin a word; captures all configuration inputs |
| word_len | input | 2 | Length code: 0=8, 1=16, 2=24, 3=32 bits |
| cpol | input | 1 | Serial clock resting level |
| gap_en | input | 1 | Enable the inter-byte pause |
| gap_len | input | 4 | Pause value; pause is gap_len + 0.5 serial periods |
| tx_word | input | 32 | Word to send, aligned to bit 31 |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| ss_n | output | 1 | Active-low select, low for the whole word |
| busy | output | 1 | High while a word is in progress |
| done | output | 1 | One-cycle pulse at word completion |
| rx_word | output | 32 | Received word, aligned to bit 31 |

## Verification
The main function is exercised with words of every length under both clock polarities. Pause values of 0, 1, 2, 3 and 15 are tried, along with one 32-bit word that has the pause disabled. The edge-spacing check separates a correct pause from one that is off by a half period, one that is placed after the last byte, and one that is inserted without being enabled. Transmit and receive patterns have distinct bytes and non-zero low bits below the selected length, so a byte-order error, a bit-order error or leakage of unused bits shows up in the captured words. A start pulse during a transfer, carrying different data and length, shows whether the configuration capture really locks out a restart.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int LEN_W  = 2;
  localparam int GAP_W  = 4;
  localparam int BYTE_IDX_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_TRAIL, ST_GAP} phase_e;

  // number of bits carried by a length code: (code+1)*8
  function automatic logic [IDX_W:0] word_bits(input logic [LEN_W-1:0] code);
    return (IDX_W+1)'({code, 3'b000}) + (IDX_W+1)'(8);
  endfunction

  // idle half periods inserted between bytes: 2*g+1
  function automatic logic [GAP_W:0] gap_halves(input logic [GAP_W-1:0] g);
    return {g, 1'b1};
  endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(HALF_CYC) + 1;
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  generate
    if (HALF_CYC > 1) begin : g_spacing
      // each half period spans HALF_CYC clocks, so ticks never touch
      p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/spi_gap_ctrl.sv
module spi_gap_ctrl
  import spi_gap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [LEN_W-1:0] word_code,
  input  logic             gap_en,
  input  logic [GAP_W-1:0] gap_len,
  output phase_e           phase,
  output logic [IDX_W-1:0] bit_idx,
  output logic             load,
  output logic             sample,
  output logic             shift,
  output logic             done
);
  logic [IDX_W-1:0] last_idx_q;
  logic             gap_en_q;
  logic [GAP_W-1:0] gap_len_q;
  logic [GAP_W:0]   gap_cnt;
  logic             last_bit, byte_end;

  assign last_bit = (bit_idx == last_idx_q);
  assign byte_end = (bit_idx[BYTE_IDX_W-1:0] == '1);
  assign load     = start && (phase == ST_IDLE);
  assign sample   = tick && (phase == ST_LEAD);
  assign shift    = tick && (phase == ST_TRAIL) && !last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= ST_IDLE;
      bit_idx    <= '0;
      last_idx_q <= '0;
      gap_en_q   <= 1'b0;
      gap_len_q  <= '0;
      gap_cnt    <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        ST_IDLE: if (start) begin
          phase      <= ST_LEAD;
          bit_idx    <= '0;
          last_idx_q <= IDX_W'(word_bits(word_code) - 1'b1);
          gap_en_q   <= gap_en;
          gap_len_q  <= gap_len;
        end
        ST_LEAD: if (tick) phase <= ST_TRAIL;
        ST_TRAIL: if (tick) begin
          if (last_bit) begin
            phase <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            if (byte_end && gap_en_q) begin
              phase   <= ST_GAP;
              gap_cnt <= gap_halves(gap_len_q) - 1'b1;
            end else begin
              phase <= ST_LEAD;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gap_cnt == '0) phase <= ST_LEAD;
          else               gap_cnt <= gap_cnt - 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != ST_IDLE) |-> (bit_idx <= last_idx_q));
  p_gap_at_byte_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_GAP) |-> (bit_idx[BYTE_IDX_W-1:0] == '0 && bit_idx != '0 && gap_en_q));
  p_gap_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_GAP) |-> (gap_cnt < gap_halves(gap_len_q)));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == ST_LEAD && !tick) |=> (phase == ST_LEAD && $stable(bit_idx)));
endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_gap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              sample,
  input  logic              shift,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_q;
  logic [IDX_W-1:0]  rx_pos;

  assign rx_pos = IDX_W'(WORD_W - 1) - bit_idx;
  assign mosi   = tx_q[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_word <= '0;
    end else if (load) begin
      tx_q    <= tx_word;
      rx_word <= '0;
    end else begin
      if (shift)  tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (sample) rx_word[rx_pos] <= miso;
    end
  end

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(mosi));
endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master
  import spi_gap_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  word_len,
  input  logic        cpol,
  input  logic        gap_en,
  input  logic [3:0]  gap_len,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        ss_n,
  output logic        busy,
  output logic        done,
  output logic [31:0] rx_word
);
  phase_e           phase;
  logic [IDX_W-1:0] bit_idx;
  logic             load, sample, shift, tick, run, cpol_q;

  assign run  = (phase != ST_IDLE);
  assign ss_n = !run;
  assign busy = run;
  assign sclk = run ? (cpol_q ^ (phase == ST_TRAIL)) : cpol;

  always_ff @(posedge clk) begin
    if (!rst_n)    cpol_q <= 1'b0;
    else if (load) cpol_q <= cpol;
  end

  spi_half_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_gap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .word_code(word_len), .gap_en(gap_en), .gap_len(gap_len),
    .phase(phase), .bit_idx(bit_idx), .load(load), .sample(sample),
    .shift(shift), .done(done)
  );

  spi_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .tx_word(tx_word),
    .sample(sample), .shift(shift), .bit_idx(bit_idx), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  p_gap_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_GAP) |-> (sclk == cpol_q));
  p_done_ss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && !$past(ss_n)));
endmodule

// File: tb/sim_spi_gap_master.sv
`timescale 1ns/1ps
module sim_spi_gap_master;
  localparam int HALF = 2;
  localparam time TCLK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] word_len = '0;
  logic cpol = 1'b1;
  logic gap_en = 1'b0;
  logic [3:0] gap_len = '0;
  logic [31:0] tx_word = '0;
  logic miso = 1'b0;
  logic sclk, mosi, ss_n, busy, done;
  logic [31:0] rx_word;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  spi_gap_master #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .word_len(word_len),
    .cpol(cpol), .gap_en(gap_en), .gap_len(gap_len), .tx_word(tx_word),
    .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .busy(busy),
    .done(done), .rx_word(rx_word)
  );

  // peripheral model and edge monitor
  logic        cur_cpol = 1'b0;
  logic        cur_ge = 1'b0;
  logic [3:0]  cur_gl = '0;
  logic [31:0] cur_mi = '0;
  logic [31:0] cap = '0;
  int          ptr = -1;
  int          edges = 0;
  int          iv_err = 0;
  time         last_t = 0;

  always @(sclk) begin
    if (!ss_n) begin
      if (sclk != cur_cpol) begin
        time expv;
        if (edges < 32) cap[31-edges] = mosi;
        if (edges > 0) begin
          if ((edges % 8 == 0) && cur_ge) expv = (2*cur_gl + 3) * HALF * TCLK;
          else                            expv = 2 * HALF * TCLK;
          if ($time - last_t != expv) iv_err++;
        end
        last_t = $time;
        edges++;
      end else if (ptr >= 0) begin
        miso = cur_mi[ptr];
        ptr--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [1:0] lc, input logic cp, input logic ge,
                          input logic [3:0] gl, input logic [31:0] tx, input logic [31:0] mi,
                          input bit poke);
    int nb;
    logic [31:0] mask, rx_exp;
    nb     = 8 * (int'(lc) + 1);
    mask   = ~(32'hFFFF_FFFF >> nb);
    rx_exp = mi & mask;
    cpol = cp;
    repeat (3) @(negedge clk);
    chk(sclk == cp, "R4 idle level", 32'(sclk), 32'(cp));
    cur_cpol = cp; cur_ge = ge; cur_gl = gl; cur_mi = mi;
    ptr = 30; miso = mi[31]; edges = 0; iv_err = 0; cap = '0;
    word_len = lc; gap_en = ge; gap_len = gl; tx_word = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!ss_n && busy, "R9 select active", 32'(ss_n), 32'(0));
    if (poke) begin
      repeat (5) @(negedge clk);
      tx_word = ~tx; word_len = 2'd0; gap_en = ~ge; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(rx_word == rx_exp, "R3 received word", rx_word, rx_exp);
    chk(ss_n && !busy, "R9 select released with done", 32'(ss_n), 32'(1));
    chk(edges == nb, "R1 clock cycles per word", 32'(edges), 32'(nb));
    chk((cap & mask) == (tx & mask), "R2 transmitted bits", cap & mask, tx & mask);
    chk(iv_err == 0, "R5 R6 edge spacing", 32'(iv_err), 32'(0));
    @(negedge clk);
    chk(!done, "R7 done single cycle", 32'(done), 32'(0));
    chk(rx_word == rx_exp, "R7 result held", rx_word, rx_exp);
    chk(sclk == cp, "R4 idle after word", 32'(sclk), 32'(cp));
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(ss_n && edges == nb, "R8 no restart queued", 32'(edges), 32'(nb));
    end
  endtask

  // {len, cpol, gap_en, gap_len, tx, miso}
  localparam logic [71:0] VEC [0:5] = '{
    {2'd0, 1'b0, 1'b1, 4'd3,  32'hA5_12_34_56, 32'h3C_FF_FF_FF},
    {2'd1, 1'b0, 1'b1, 4'd0,  32'hC3_96_0F_0F, 32'h81_7E_AA_AA},
    {2'd2, 1'b1, 1'b1, 4'd2,  32'h12_34_56_FF, 32'hF0_0F_5A_77},
    {2'd3, 1'b1, 1'b0, 4'd5,  32'hDE_AD_BE_EF, 32'h01_23_45_67},
    {2'd3, 1'b0, 1'b1, 4'd15, 32'h80_01_7F_FE, 32'hCA_FE_BA_BE},
    {2'd3, 1'b1, 1'b1, 4'd1,  32'h00_00_00_00, 32'hFF_FF_FF_FF}
  };

  initial begin
    repeat (2) @(negedge clk);
    chk(ss_n && !busy && !done, "R9 reset select idle", 32'(ss_n), 32'(1));
    chk(sclk == 1'b1, "R4 reset clock level", 32'(sclk), 32'(1));
    chk(rx_word == '0, "R3 reset received word", rx_word, 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++)
      run_word(VEC[i][71:70], VEC[i][69], VEC[i][68], VEC[i][67:64],
               VEC[i][63:32], VEC[i][31:0], 1'b0);
    // directed: start during a transfer must be ignored (R8)
    run_word(2'd2, 1'b0, 1'b1, 4'd1, 32'h5A_C3_3C_00, 32'h96_69_E1_00, 1'b1);
    // directed: shortest word with pause enabled, polarity high (R6)
    run_word(2'd0, 1'b1, 1'b1, 4'd15, 32'h7F_FF_FF_FF, 32'h80_00_00_00, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule